// File: doc/BRIEF.md
# Interrupt Request Latch with Per-Line Trigger Mode

This block conditions the raw interrupt lines of an eight-input interrupt controller before any priority logic sees them. Every line passes through a two-stage synchroniser. A per-line previous-level register follows the synchronised level on every clock, and the block uses it to detect rising transitions. A request vector holds the pending requests. Each line takes its request from the input in one of two ways, chosen by a bit of a trigger-mode register:

- **Level mode:** the request follows the input.
- **Edge mode:** a rising transition latches the request, and the request stays set until an acknowledge clears it.

Software writes the trigger-mode register through a byte-wide port and can read it back. A fixed per-instance mask filters each write, so lines that must stay edge-triggered can never be switched to level mode. The default mask is `8'hF8` for a primary unit. A cascaded secondary unit would use `8'hDE`.

Each rising transition of a synchronised line is an input event. For every event the block emits a one-cycle outcome pulse: masked, new request, or coalesced into a request that was already pending. An acknowledge from the downstream priority logic names one line and clears that line's latched request, but only if the line is in edge mode.

Top module: `irq_req_latch`

## Requirements
- R1: After reset the request vector, the trigger-mode register and all three outcome vectors read zero. All lines are therefore in edge mode.
- R2: A change on `line_in` reaches `req_out` on the third rising clock edge after it is applied. Two of these edges are synchroniser stages and one is the request register.
- R3: For a line in edge mode (trigger bit 0), a rising synchronised level sets the request bit. The bit stays set after the input returns low.
- R4: For a line in edge mode, an input held high after its request was acknowledged creates no new request until the input has gone low and risen again.
- R5: For a line in level mode (trigger bit 1), the request bit is set while the synchronised input is high and cleared once it is low.
- R6: A write to the trigger-mode register stores the written byte ANDed with the parameter `TRIG_MASK`. The stored value is visible on `trig_rdata` after the next clock edge.
- R7: An acknowledge with `ack_line` = n clears request bit n only if line n is in edge mode. A level-mode request is not affected.
- R8: A rising event on an unmasked line (`mask_in` bit 0) whose request bit was clear gives a one-cycle pulse on `evt_new` for that line. The pulse appears in the same cycle the request bit appears.
- R9: A rising event on an unmasked line whose request bit was already set gives a one-cycle pulse on `evt_coal` instead of `evt_new`.
- R10: A rising event on a masked line (`mask_in` bit 1) gives a one-cycle pulse on `evt_masked` only. The request bit is still latched.
- R11: If an acknowledge of an edge-mode line coincides with a new rising event on that same line, the request bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | LINES | Raw asynchronous interrupt lines |
| mask_in | input | LINES | Per-line mask from the controller's mask register |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_line | input | AW | Index of the acknowledged line |
| trig_wr | input | 1 | Trigger-mode register write strobe |
| trig_wdata | input | LINES | Trigger-mode write data, 1 = level mode |
| trig_rdata | output | LINES | Stored trigger-mode value |
| req_out | output | LINES | Latched request vector |
| evt_new | output | LINES | Pulse: new unmasked request |
| evt_coal | output | LINES | Pulse: event merged into a pending request |
| evt_masked | output | LINES | Pulse: event on a masked line |

## Verification
The bench checks the trigger write filter by writing all ones. It expects exactly the instance mask back, both for the default mask and for a second mask; a design that ignored the mask would let a fixed-edge line become level-sensitive. The bench also checks three edge-mode behaviours:

- A request must survive the input going low. A design that confused the modes would drop it.
- A request acknowledged while the input stays high must not come back. A level-style update would re-raise it.
- An acknowledge that lands in the same cycle as a fresh edge must leave the request set. A clear-wins ordering would lose an interrupt.

It also checks that an acknowledge leaves a level-mode request set, and that the third-edge latency holds exactly. An extra or missing register stage would shift every pulse.

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int LINES = 8,
  parameter logic [LINES-1:0] TRIG_MASK = 8'hF8,
  localparam int AW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_in,
  input  logic [LINES-1:0] mask_in,
  input  logic             ack_valid,
  input  logic [AW-1:0]    ack_line,
  input  logic             trig_wr,
  input  logic [LINES-1:0] trig_wdata,
  output logic [LINES-1:0] trig_rdata,
  output logic [LINES-1:0] req_out,
  output logic [LINES-1:0] evt_new,
  output logic [LINES-1:0] evt_coal,
  output logic [LINES-1:0] evt_masked
);

  logic [LINES-1:0] meta_q, lvl_q, prev_q, trig_q, req_q;
  logic [LINES-1:0] rise, ack_vec, req_nxt;

  assign rise    = lvl_q & ~prev_q;
  assign ack_vec = ack_valid ? (LINES'(1) << ack_line) : '0;

  // level lines follow the input; edge lines hold until acked, new edge wins
  assign req_nxt = (trig_q & lvl_q) |
                   (~trig_q & ((req_q & ~ack_vec) | rise));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= '0;
      lvl_q      <= '0;
      prev_q     <= '0;
      trig_q     <= '0;
      req_q      <= '0;
      evt_new    <= '0;
      evt_coal   <= '0;
      evt_masked <= '0;
    end else begin
      meta_q     <= line_in;
      lvl_q      <= meta_q;
      prev_q     <= lvl_q;
      req_q      <= req_nxt;
      evt_masked <= rise & mask_in;
      evt_new    <= rise & ~mask_in & ~req_q;
      evt_coal   <= rise & ~mask_in & req_q;
      if (trig_wr) trig_q <= trig_wdata & TRIG_MASK;
    end
  end

  assign trig_rdata = trig_q;
  assign req_out    = req_q;

endmodule

module irq_req_latch_chk #(
  parameter int LINES = 8,
  parameter logic [LINES-1:0] TRIG_MASK = 8'hF8,
  localparam int AW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LINES-1:0] sync_lvl,
  input logic             ack_valid,
  input logic [AW-1:0]    ack_line,
  input logic             trig_wr,
  input logic [LINES-1:0] trig_wdata,
  input logic [LINES-1:0] trig_rdata,
  input logic [LINES-1:0] req_out,
  input logic [LINES-1:0] evt_new,
  input logic [LINES-1:0] evt_coal,
  input logic [LINES-1:0] evt_masked
);

  logic [LINES-1:0] ack_vec;
  assign ack_vec = ack_valid ? (LINES'(1) << ack_line) : '0;

  AST_OUTCOME_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_new & evt_coal) | (evt_new & evt_masked) | (evt_coal & evt_masked)) == '0); // R8

  AST_NEW_SETS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_new & ~req_out) == '0); // R8

  AST_COAL_WAS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_coal & ~$past(req_out)) == '0); // R9

  AST_TRIG_FILTERED: assert property (@(posedge clk) disable iff (!rst_n)
    trig_wr |=> trig_rdata == ($past(trig_wdata) & TRIG_MASK)); // R6

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_out ^ $past(sync_lvl)) & $past(trig_rdata)) == '0); // R5

  AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_out) & ~req_out & ~$past(trig_rdata) & ~$past(ack_vec)) == '0); // R3

endmodule

bind irq_req_latch irq_req_latch_chk #(.LINES(LINES), .TRIG_MASK(TRIG_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_lvl(lvl_q), .ack_valid(ack_valid),
  .ack_line(ack_line), .trig_wr(trig_wr), .trig_wdata(trig_wdata),
  .trig_rdata(trig_rdata), .req_out(req_out), .evt_new(evt_new),
  .evt_coal(evt_coal), .evt_masked(evt_masked)
);

// File: tb/irq_req_latch_bench.sv
module irq_req_latch_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic [7:0] line_in = 0, mask_in = 0, trig_wdata = 0;
  logic ack_valid = 0, trig_wr = 0;
  logic [2:0] ack_line = 0;
  logic [7:0] trig_rdata, req_out, evt_new, evt_coal, evt_masked;
  logic [7:0] alt_rdata, alt_req, alt_new, alt_coal, alt_masked;
  logic alt_wr = 0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  irq_req_latch u_irq_req_latch (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .mask_in(mask_in),
    .ack_valid(ack_valid), .ack_line(ack_line), .trig_wr(trig_wr),
    .trig_wdata(trig_wdata), .trig_rdata(trig_rdata), .req_out(req_out),
    .evt_new(evt_new), .evt_coal(evt_coal), .evt_masked(evt_masked));

  irq_req_latch #(.TRIG_MASK(8'hDE)) u_irq_req_latch_alt (
    .clk(clk), .rst_n(rst_n), .line_in(8'h00), .mask_in(8'h00),
    .ack_valid(1'b0), .ack_line(3'd0), .trig_wr(alt_wr),
    .trig_wdata(trig_wdata), .trig_rdata(alt_rdata), .req_out(alt_req),
    .evt_new(alt_new), .evt_coal(alt_coal), .evt_masked(alt_masked));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 req", req_out, 8'h00);
    chk("R1 trig", trig_rdata, 8'h00);
    chk("R1 events", evt_new | evt_coal | evt_masked, 8'h00);
  endtask

  task automatic write_trig(logic [7:0] v);
    trig_wdata = v; trig_wr = 1; cyc(1); trig_wr = 0;
  endtask

  task automatic t_trig;
    trig_wdata = 8'hFF; trig_wr = 1; alt_wr = 1; cyc(1); trig_wr = 0; alt_wr = 0;
    chk("R6 primary mask", trig_rdata, 8'hF8);
    chk("R6 secondary mask", alt_rdata, 8'hDE);
    write_trig(8'h07);
    chk("R6 fixed edge lines", trig_rdata, 8'h00);
    write_trig(8'hF0);
    chk("R6 readback", trig_rdata, 8'hF0);
  endtask

  task automatic t_edge;
    line_in[0] = 1; cyc(2);
    chk("R2 not yet", req_out & 8'h01, 8'h00);
    cyc(1);
    chk("R3 edge set", req_out & 8'h01, 8'h01);
    chk("R8 new pulse", evt_new, 8'h01);
    cyc(1);
    chk("R8 pulse ends", evt_new, 8'h00);
    line_in[0] = 0; cyc(4);
    chk("R3 latched after low", req_out & 8'h01, 8'h01);
    line_in[0] = 1; cyc(3);
    chk("R9 coalesced", evt_coal, 8'h01);
    chk("R9 no new", evt_new, 8'h00);
  endtask

  task automatic t_ack;
    ack_line = 0; ack_valid = 1; cyc(1); ack_valid = 0;
    chk("R7 edge ack clears", req_out & 8'h01, 8'h00);
    cyc(5);
    chk("R4 held high no rerequest", req_out & 8'h01, 8'h00);
    line_in[0] = 0; cyc(4);
  endtask

  task automatic t_level;
    line_in[5] = 1; cyc(3);
    chk("R5 level set", req_out & 8'h20, 8'h20);
    chk("R8 level new", evt_new, 8'h20);
    ack_line = 5; ack_valid = 1; cyc(1); ack_valid = 0;
    chk("R7 level ack ignored", req_out & 8'h20, 8'h20);
    line_in[5] = 0; cyc(2);
    chk("R5 still set before sync", req_out & 8'h20, 8'h20);
    cyc(1);
    chk("R5 level cleared", req_out & 8'h20, 8'h00);
  endtask

  task automatic t_mask;
    mask_in = 8'h02; line_in[1] = 1; cyc(3);
    chk("R10 masked pulse", evt_masked, 8'h02);
    chk("R10 no new", evt_new | evt_coal, 8'h00);
    chk("R10 still latched", req_out & 8'h02, 8'h02);
    mask_in = 0; ack_line = 1; ack_valid = 1; cyc(1); ack_valid = 0;
    line_in[1] = 0; cyc(4);
    chk("R7 cleanup", req_out & 8'h02, 8'h00);
  endtask

  task automatic t_race;
    line_in[2] = 1; cyc(2);
    ack_line = 2; ack_valid = 1; cyc(1); ack_valid = 0;
    chk("R11 edge beats ack", req_out & 8'h04, 8'h04);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1;
    cyc(1);
    t_reset();
    t_trig();
    t_edge();
    t_ack();
    t_level();
    t_mask();
    t_race();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule